// File: doc/BRIEF.md
# I2C Register-Access Controller

This block is a single-controller engine for a two-wire open-drain serial bus. It runs whole register transactions for a user. A one-cycle `start` strobe supplies a 7-bit target address, a register index, a read/write select and a write byte. For a write, the block sends the address with the write bit, then the register index, then the data byte, and then issues a stop. For a read, it sends the address with the write bit and the register index, issues a repeated start, and addresses the target again with the read bit. It then receives one byte, answers it with a NACK and issues a stop.

The block never drives either line high. Each line is either pulled low through `sda_oe`/`scl_oe` or released to its pull-up. The serial clock is made from the system clock: each SCL half-period lasts `HALF_PERIOD` system clocks. Both line inputs pass through a two-flop synchronizer, and SDA is sampled at the midpoint of each SCL-high phase. When a bus frame is refused, the block flags an error and stops the bus. When it loses arbitration to another controller, it releases the bus at once.

The sequencer has nine states:
- `S_IDLE`: the bus is released.
- `S_START`: SDA is low while SCL is high.
- `S_BIT_LO` and `S_BIT_HI`: the low and high halves of one bit cell.
- `S_RS_LO` and `S_RS_HI`: SDA is released before a repeated start.
- `S_STOP_LO`, `S_STOP_HI` and `S_FINISH`: the stop condition and the bus-free time after it.

The transitions are as follows:
- idle→start on the strobe.
- start→bit-low.
- bit-low→bit-high.
- bit-high→bit-low for the next bit or frame.
- bit-high→repeated-start-low after the register index of a read.
- bit-high→stop-low after the last acknowledge or after a refused frame.
- bit-high→idle on lost arbitration.
- repeated-start-low→repeated-start-high→start.
- stop-low→stop-high→finish→idle.

Top module: `i2c_regacc`

## Requirements
- R1: After reset, and whenever the block is idle, both `sda_oe` and `scl_oe` are 0, `busy` and `done` are 0, and `ack_error` and `arb_lost` are 0 until the first transaction ends.
- R2: Every SCL low phase lasts exactly `HALF_PERIOD` system clocks. SDA changes while SCL is high only to form a start (falling) or a stop (rising). `sda_oe` and `scl_oe` never change on the same clock edge.
- R3: A write puts this sequence on the bus: start, byte {addr,0}, ACK, register index, ACK, data byte, ACK, stop. All bytes are sent most significant bit first, an ACK is a 0 bit, and `done` rises with `ack_error`=0 and `arb_lost`=0.
- R4: A read puts this sequence on the bus: start, {addr,0}, ACK, register index, ACK, repeated start, {addr,1}, ACK, one byte driven by the target, a 1 bit (NACK) from the controller, stop. `rdata` equals that byte while `done` is high.
- R5: If the address frame gets a NACK (SDA high in the acknowledge bit), no further frame is sent. A stop follows, and `done` rises with `ack_error`=1.
- R6: If the register-index or data frame of a write gets a NACK, a stop follows at once, and `done` rises with `ack_error`=1.
- R7: If SDA reads low while the controller is releasing it for a 1 data bit, or SCL reads low during the controller's SCL-high phase, the block releases both lines and goes idle without a stop. `done` then pulses with `arb_lost`=1 and `ack_error`=0.
- R8: `busy` is high from the clock after an accepted `start` until `done`. `done` is a one-cycle pulse. A `start` while busy is ignored.
- R9: `ack_error` and `arb_lost` hold their values until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle command strobe, accepted only while idle |
| tgt_addr | input | 7 | Target address |
| reg_idx | input | 8 | Register index sent as the first data frame |
| rd_req | input | 1 | 1 = register read, 0 = register write |
| wdata | input | 8 | Byte written by a write command |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 8 | Byte read, valid while `done` is high |
| ack_error | output | 1 | A frame sent by the controller was refused |
| arb_lost | output | 1 | The bus was lost to another controller |
| sda_in | input | 1 | Sensed SDA level |
| scl_in | input | 1 | Sensed SCL level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |

## Verification
A wrong frame register or bit count shows up on the bus sequence within one bit cell: a missing or extra byte, a repeated start in a write, or a stop in the wrong place. The bench's event trace catches it when the transaction's done pulse arrives. A corrupted shift register shows up as a wrong byte in the trace, or as a wrong `rdata` in the same done cycle. A sequencer stuck in a state shows up as an SCL low phase of the wrong length, at the next rising SCL edge, or as a done pulse that never comes.

// File: rtl/i2c_regacc_pkg.sv
package i2c_regacc_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_BIT_LO,
        S_BIT_HI,
        S_RS_LO,
        S_RS_HI,
        S_STOP_LO,
        S_STOP_HI,
        S_FINISH
    } state_t;

    typedef enum logic [2:0] {
        F_ADDR_W,
        F_REG,
        F_WDATA,
        F_ADDR_R,
        F_RDATA
    } frame_t;

    localparam logic [3:0] ACK_SLOT = 4'd8;

endpackage

// File: rtl/i2c_regacc_sync.sv
module i2c_regacc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Lines idle high, so both stages reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/i2c_regacc_phase.sv
module i2c_regacc_phase #(
    parameter int HALF = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic at_mid,
    output logic at_end
);
    localparam int CW = $clog2(HALF) + 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] MID  = CW'(HALF / 2);

    logic [CW-1:0] cnt;

    // Counts the clocks spent in the current state and saturates at LAST.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign at_mid = (cnt == MID);
    assign at_end = (cnt == LAST);
endmodule

// File: rtl/i2c_regacc.sv
module i2c_regacc
    import i2c_regacc_pkg::*;
#(
    parameter int HALF_PERIOD = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [6:0] tgt_addr,
    input  logic [7:0] reg_idx,
    input  logic       rd_req,
    input  logic [7:0] wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rdata,
    output logic       ack_error,
    output logic       arb_lost,
    input  logic       sda_in,
    input  logic       scl_in,
    output logic       sda_oe,
    output logic       scl_oe
);
    state_t      state, nxt;
    frame_t      frame;
    logic [3:0]  bitn;
    logic [7:0]  shreg;
    logic        samp;
    logic [6:0]  addr_q;
    logic [7:0]  reg_q, wd_q;
    logic        rd_q;
    logic [1:0]  lines_s;
    logic        sda_s, scl_s;
    logic        at_mid, at_end;
    logic        ack_slot, sda_rel, tx_one, lose;
    frame_t      frame_nx;

    i2c_regacc_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_in, sda_in}),
        .q    (lines_s)
    );
    assign sda_s = lines_s[0];
    assign scl_s = lines_s[1];

    i2c_regacc_phase #(.HALF(HALF_PERIOD)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (nxt != state),
        .at_mid(at_mid),
        .at_end(at_end)
    );

    function automatic frame_t frame_after(frame_t f, logic rd);
        case (f)
            F_ADDR_W: return F_REG;
            F_REG:    return rd ? F_ADDR_R : F_WDATA;
            F_ADDR_R: return F_RDATA;
            default:  return f;
        endcase
    endfunction

    function automatic logic [7:0] frame_load(frame_t f, logic [6:0] a,
                                              logic [7:0] r, logic [7:0] w);
        case (f)
            F_ADDR_W: return {a, 1'b0};
            F_REG:    return r;
            F_WDATA:  return w;
            F_ADDR_R: return {a, 1'b1};
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic logic scl_pull(state_t s);
        case (s)
            S_BIT_LO, S_RS_LO, S_STOP_LO: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    function automatic logic sda_pull(state_t s, logic rel);
        case (s)
            S_START, S_STOP_LO, S_STOP_HI: return 1'b1;
            S_BIT_LO, S_BIT_HI:            return !rel;
            default:                       return 1'b0;
        endcase
    endfunction

    // Bit-cell decode: the acknowledge bit and every received bit leave SDA released.
    assign ack_slot = (bitn == ACK_SLOT);
    assign sda_rel  = ack_slot || (frame == F_RDATA) || shreg[7];
    assign tx_one   = !ack_slot && (frame != F_RDATA) && shreg[7];
    assign lose     = !scl_s || (tx_one && !sda_s);
    assign frame_nx = frame_after(frame, rd_q);
    assign busy     = (state != S_IDLE);

    // Next-state decode.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start)  nxt = S_START;
            S_START:   if (at_end) nxt = S_BIT_LO;
            S_BIT_LO:  if (at_end) nxt = S_BIT_HI;
            S_BIT_HI: begin
                if (at_mid && lose) begin
                    nxt = S_IDLE;
                end else if (at_end) begin
                    if (!ack_slot)      nxt = S_BIT_LO;
                    else if (ack_error) nxt = S_STOP_LO;
                    else begin
                        unique case (frame)
                            F_ADDR_W:         nxt = S_BIT_LO;
                            F_REG:            nxt = rd_q ? S_RS_LO : S_BIT_LO;
                            F_ADDR_R:         nxt = S_BIT_LO;
                            F_WDATA, F_RDATA: nxt = S_STOP_LO;
                        endcase
                    end
                end
            end
            S_RS_LO:   if (at_end) nxt = S_RS_HI;
            S_RS_HI:   if (at_end) nxt = S_START;
            S_STOP_LO: if (at_end) nxt = S_STOP_HI;
            S_STOP_HI: if (at_end) nxt = S_FINISH;
            S_FINISH:  if (at_end) nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Frame, bit and shift datapath, together with the result flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame     <= F_ADDR_W;
            bitn      <= '0;
            shreg     <= 8'hFF;
            samp      <= 1'b1;
            addr_q    <= '0;
            reg_q     <= '0;
            wd_q      <= '0;
            rd_q      <= 1'b0;
            rdata     <= '0;
            ack_error <= 1'b0;
            arb_lost  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= (state != S_IDLE) && (nxt == S_IDLE);
            if (state == S_IDLE && start) begin
                addr_q    <= tgt_addr;
                reg_q     <= reg_idx;
                wd_q      <= wdata;
                rd_q      <= rd_req;
                frame     <= F_ADDR_W;
                bitn      <= '0;
                shreg     <= {tgt_addr, 1'b0};
                ack_error <= 1'b0;
                arb_lost  <= 1'b0;
            end
            if (state == S_BIT_HI && at_mid) begin
                samp <= sda_s;
                if (lose)
                    arb_lost <= 1'b1;
                else if (ack_slot && frame != F_RDATA && sda_s)
                    ack_error <= 1'b1;
            end
            if (state == S_BIT_HI && at_end) begin
                if (!ack_slot) begin
                    shreg <= {shreg[6:0], samp};
                    bitn  <= bitn + 4'd1;
                end else begin
                    bitn  <= '0;
                    if (frame == F_RDATA) rdata <= shreg;
                    frame <= frame_nx;
                    shreg <= frame_load(frame_nx, addr_q, reg_q, wd_q);
                end
            end
        end
    end

    // Line outputs: SCL follows the next state, SDA follows one clock behind.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            scl_oe <= scl_pull(nxt);
            sda_oe <= sda_pull(state, sda_rel);
        end
    end
endmodule

// File: rtl/i2c_regacc_chk.sv
module i2c_regacc_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic ack_error,
    input logic arb_lost,
    input logic sda_oe,
    input logic scl_oe
);
    a_r1_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (!sda_oe && !scl_oe));

    a_r2_one_line_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe) |-> $stable(sda_oe));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(ack_error && arb_lost));

    a_r7_lost_clock_free: assert property (@(posedge clk) disable iff (!rst_n)
        (done && arb_lost) |-> !scl_oe);
endmodule

bind i2c_regacc i2c_regacc_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ack_error(ack_error),
    .arb_lost (arb_lost),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe)
);

// File: tb/i2c_regacc_tb_top.sv
`timescale 1ns/1ps
module i2c_regacc_tb_top;
    localparam int HALF = 8;
    localparam logic [6:0] TADDR = 7'h50;
    localparam int EV_S = 1000, EV_P = 1001, EV_ACK = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] reg_i = '0, wdat = '0;
    logic rd = 1'b0;
    logic busy, done, ack_error, arb_lost, sda_oe, scl_oe;
    logic [7:0] rdata;
    logic tgt_pull = 1'b0;
    logic rival = 1'b0;
    logic sda_line, scl_line;

    always #10 clk = ~clk;

    assign sda_line = !(sda_oe | tgt_pull | rival);
    assign scl_line = !scl_oe;

    i2c_regacc #(.HALF_PERIOD(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(addr),
        .reg_idx(reg_i), .rd_req(rd), .wdata(wdat), .busy(busy), .done(done),
        .rdata(rdata), .ack_error(ack_error), .arb_lost(arb_lost),
        .sda_in(sda_line), .scl_in(scl_line), .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    int tests = 0, fails = 0;
    int ev_q[$], exp_q[$];
    logic [7:0] mem [256];
    logic nack_data = 1'b0;
    int per_err = 0, idle_err = 0;

    // Bus monitor and behavioural target, evaluated on every falling clock edge.
    logic p_scl = 1'b1, p_sda = 1'b1, p_busy = 1'b0;
    int lowcnt = 0, mbit = 0, t_bit = 0, t_frame = 0;
    logic [7:0] mbyte = '0, t_byte = '0, ptr = '0;
    logic t_act = 0, t_sel = 0, t_rw = 0, t_tx = 0, t_ack = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
            p_scl = 1; p_sda = 1; t_act = 0; tgt_pull = 0; lowcnt = 0;
        end else begin
            if (!scl_line) lowcnt++;
            if (!p_scl && scl_line) begin
                if (lowcnt != HALF) per_err++;
                lowcnt = 0;
            end
            if (!busy && !p_busy && (sda_oe || scl_oe)) idle_err++;
            if (p_scl && scl_line && p_sda && !sda_line) begin
                ev_q.push_back(EV_S);
                mbit = 0; t_act = 1; t_bit = 0; t_frame = 0;
                t_sel = 0; t_tx = 0; tgt_pull = 0;
            end else if (p_scl && scl_line && !p_sda && sda_line) begin
                ev_q.push_back(EV_P);
                t_act = 0; t_tx = 0; tgt_pull = 0;
            end else if (!p_scl && scl_line) begin
                if (mbit < 8) begin
                    mbyte = {mbyte[6:0], sda_line}; mbit++;
                end else begin
                    ev_q.push_back(int'(mbyte));
                    ev_q.push_back(EV_ACK + int'(sda_line));
                    mbit = 0;
                end
                if (t_act) begin
                    if (t_bit < 8) begin
                        if (!t_tx) t_byte = {t_byte[6:0], sda_line};
                        if (t_bit == 7 && !t_tx) begin
                            if (t_frame == 0) begin
                                t_sel = (t_byte[7:1] == TADDR);
                                t_rw  = t_byte[0];
                                t_ack = t_sel;
                            end else if (!t_sel) t_ack = 0;
                            else if (t_frame == 1) begin
                                ptr = t_byte; t_ack = 1;
                            end else if (nack_data) t_ack = 0;
                            else begin
                                mem[ptr] = t_byte; t_ack = 1;
                            end
                        end
                        t_bit++;
                    end else begin
                        if (t_tx && sda_line) t_tx = 0;
                        if (t_frame == 0) t_tx = t_sel && t_rw;
                        t_bit = 0; t_frame++;
                    end
                end
            end else if (p_scl && !scl_line && t_act) begin
                if (t_bit == 8) tgt_pull = t_tx ? 1'b0 : t_ack;
                else            tgt_pull = t_tx ? !mem[ptr][7-t_bit] : 1'b0;
            end
            p_scl = scl_line; p_sda = sda_line; p_busy = busy;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_seq(input string req);
        int bad = (ev_q.size() != exp_q.size()) ? 1 : 0;
        if (!bad)
            foreach (exp_q[i]) if (ev_q[i] != exp_q[i]) bad = 1;
        tests++;
        if (bad) begin
            fails++;
            $display("FAIL %s bus trace actual=%p expected=%p", req, ev_q, exp_q);
        end
        ev_q.delete(); exp_q.delete();
    endtask

    task automatic exp_write(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                             input bit a_ok, input bit d_ok);
        exp_q.push_back(EV_S); exp_q.push_back(int'({a, 1'b0}));
        exp_q.push_back(EV_ACK + (a_ok ? 0 : 1));
        if (a_ok) begin
            exp_q.push_back(int'(r)); exp_q.push_back(EV_ACK);
            exp_q.push_back(int'(d)); exp_q.push_back(EV_ACK + (d_ok ? 0 : 1));
        end
        exp_q.push_back(EV_P);
    endtask

    task automatic exp_read(input logic [6:0] a, input logic [7:0] r, input logic [7:0] v);
        exp_q.push_back(EV_S); exp_q.push_back(int'({a, 1'b0})); exp_q.push_back(EV_ACK);
        exp_q.push_back(int'(r)); exp_q.push_back(EV_ACK);
        exp_q.push_back(EV_S); exp_q.push_back(int'({a, 1'b1})); exp_q.push_back(EV_ACK);
        exp_q.push_back(int'(v)); exp_q.push_back(EV_ACK + 1); exp_q.push_back(EV_P);
    endtask

    logic g_busy, g_done, g_done2, g_ack, g_arb, g_scl;
    logic [7:0] g_rd;

    task automatic run_txn(input logic [6:0] a, input logic [7:0] r, input logic rq,
                           input logic [7:0] d);
        int n = 0;
        @(negedge clk);
        addr = a; reg_i = r; rd = rq; wdat = d; start = 1;
        @(negedge clk);
        start = 0; g_busy = busy;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        g_done = done; g_rd = rdata; g_ack = ack_error; g_arb = arb_lost; g_scl = scl_oe;
        @(negedge clk);
        g_done2 = done;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset lines", {sda_oe, scl_oe}, 0);
        chk("R1 reset flags", {ack_error, arb_lost}, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);

        // R3 register write
        exp_write(TADDR, 8'h3C, 8'hA5, 1, 1);
        run_txn(TADDR, 8'h3C, 0, 8'hA5);
        chk("R8 busy after start", g_busy, 1);
        chk("R3 done", g_done, 1);
        chk("R8 done one cycle", g_done2, 0);
        chk("R3 flags", {g_ack, g_arb}, 0);
        chk("R3 target register", mem[8'h3C], 8'hA5);
        chk_seq("R3");

        // R4 read back, then a read of an untouched register
        exp_read(TADDR, 8'h3C, 8'hA5);
        run_txn(TADDR, 8'h3C, 1, 8'h00);
        chk("R4 rdata", g_rd, 8'hA5);
        chk("R4 flags", {g_ack, g_arb}, 0);
        chk_seq("R4");
        exp_read(TADDR, 8'h81, 8'h81 ^ 8'h5A);
        run_txn(TADDR, 8'h81, 1, 8'h00);
        chk("R4 rdata default", g_rd, 8'h81 ^ 8'h5A);
        chk_seq("R4 second read");

        // R5 address NACK, write and read
        exp_write(7'h22, 8'h3C, 8'h00, 0, 1);
        run_txn(7'h22, 8'h3C, 0, 8'h00);
        chk("R5 ack_error write", g_ack, 1);
        chk("R5 register untouched", mem[8'h3C], 8'hA5);
        chk_seq("R5 write");
        exp_write(7'h22, 8'h10, 8'h00, 0, 1);
        run_txn(7'h22, 8'h10, 1, 8'h00);
        chk("R5 ack_error read", g_ack, 1);
        chk_seq("R5 read");

        // R6 data NACK
        nack_data = 1;
        exp_write(TADDR, 8'h3C, 8'h11, 1, 0);
        run_txn(TADDR, 8'h3C, 0, 8'h11);
        nack_data = 0;
        chk("R6 ack_error", g_ack, 1);
        chk("R6 arb clear", g_arb, 0);
        chk_seq("R6");

        // R9 flags cleared by next start
        exp_write(TADDR, 8'h20, 8'h5F, 1, 1);
        run_txn(TADDR, 8'h20, 0, 8'h5F);
        chk("R9 ack_error cleared", g_ack, 0);
        chk_seq("R9 after error");

        // R7 arbitration loss: rival holds SDA low from the first SCL low phase
        fork
            run_txn(TADDR, 8'h01, 0, 8'h11);
            begin
                @(negedge clk);
                while (scl_line) @(negedge clk);
                rival = 1;
            end
        join
        chk("R7 arb_lost", g_arb, 1);
        chk("R7 no ack_error", g_ack, 0);
        chk("R7 scl released", g_scl, 0);
        chk("R7 sda released", sda_oe, 0);
        rival = 0;
        repeat (4) @(negedge clk);
        exp_q.push_back(EV_S); exp_q.push_back(EV_P);
        chk_seq("R7 no stop from controller");
        chk("R7 register untouched", mem[8'h01], 8'h01 ^ 8'h5A);

        exp_write(TADDR, 8'h21, 8'h66, 1, 1);
        run_txn(TADDR, 8'h21, 0, 8'h66);
        chk("R9 arb_lost cleared", g_arb, 0);
        chk_seq("R9 after arbitration");

        // R8 start while busy ignored
        exp_write(TADDR, 8'h10, 8'h77, 1, 1);
        fork
            run_txn(TADDR, 8'h10, 0, 8'h77);
            begin
                repeat (150) @(negedge clk);
                addr = 7'h22; rd = 1; start = 1;
                @(negedge clk);
                start = 0;
            end
        join
        repeat (40) @(negedge clk);
        chk("R8 second start ignored busy", busy, 0);
        chk("R8 register written once", mem[8'h10], 8'h77);
        chk_seq("R8 trace unchanged");

        chk("R2 scl low period", per_err, 0);
        chk("R1 idle lines", idle_err, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule